// File: doc/BRIEF.md
# Interval Timer with Periodic and One-Shot Modes

This block is a bus-mapped interval timer. Software programs a 64-bit period through two 32-bit words, picks one of two run modes through a control word, and sets the enable bit. From then on a 64-bit up-counter advances by one on every clock cycle in which the `tick_en` strobe is high.

The timer expires on the tick that arrives while the counter already holds the period value. Each expiry sets a sticky status flag. In periodic mode the counter then returns to zero and adopts the most recently written period. In one-shot mode the counter stays at the period value and the enable bit clears itself.

A single level interrupt follows the status flag whenever the unmask bit is set. The control word sits at an address chosen by a parameter, so each chip variant can place it where its register map needs it. The sequencing is a three-state machine:
- `ST_IDLE` (stopped)
- `ST_COUNT` (running)
- `ST_HALT` (one-shot finished, counter frozen at the period value)

Its transitions are:
- *arm*: `ST_IDLE` or `ST_HALT` to `ST_COUNT`, when enable is written from 0 to 1.
- *disarm*: `ST_COUNT` to `ST_IDLE`, when enable is written as 0.
- *expire-once*: `ST_COUNT` to `ST_HALT`, on expiry in one-shot mode.
- *expire-wrap*: `ST_COUNT` to `ST_COUNT`, on expiry in periodic mode.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every register reads zero: period words, counter words, control and status. `irq` is low.
- R2: The period low word reads back at 0x00 and the high word at 0x04. The counter low word reads at 0x08 and the high word at 0x0C. All reads are combinational from `bus_addr`.
- R3: The control word sits at parameter `CTRL_OFS` (default 0x10). Bit 0 is enable, bit 1 is mode (0 = periodic, 1 = one-shot) and bit 2 is unmask. The control word reads back those three bits. Writing enable from 0 to 1 clears the counter to 0, captures the period and starts counting. Rewriting enable=1 while running does not restart the count.
- R4: While running, the counter rises by exactly 1 on each edge with `tick_en` high. It holds on edges with `tick_en` low.
- R5: In periodic mode, the tick taken while the counter equals the period P sets status and returns the counter to 0. Expiry therefore recurs every P+1 ticks, and while running the counter never exceeds the period in use.
- R6: In one-shot mode, expiry after P+1 ticks sets status, freezes the counter at P and clears the enable bit. Control then reads with bit 0 at 0, and further ticks do not move the counter.
- R7: Status is bit 0 at 0x18. It stays set until a 1 is written to bit 0 there. Writing 0 has no effect. An expiry in the same cycle as a clear leaves status set.
- R8: `irq` is high exactly when status is set and unmask is 1. Status can be set and read while masked, with `irq` low.
- R9: A period written while running does not change the current period. It is used from the next periodic reload onward.
- R10: Writing enable as 0 stops counting on that edge and takes priority over a tick in the same cycle. The counter keeps its value and status is not cleared.
- R11: Expiry compares all 64 bits. A period with a nonzero high word does not expire when the low words match.
- R12: Reads from unmapped addresses return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count strobe; the counter advances on edges where it is high |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt: status AND unmask |

## Verification
Register writes, counter steps and status changes are all visible on the read bus right after the edge that takes them, one register deep. An interrupt change follows on `irq` with the same latency as its status bit. A write of enable=1 leaves the counter at 0, and a counter that has taken n ticks from arming shows n mod (P+1) in periodic mode, or min(n, P) in one-shot mode. The bench drives writes and `tick_en` on falling edges, counts the edges that saw `tick_en` high, and samples the read bus in the following low phase. In that phase every result of the preceding edge has settled and no further edge has occurred.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CNT_W      = 64;
    localparam int unsigned NWORDS     = CNT_W / WORD_W;

    // fixed byte offsets of the register map
    localparam int unsigned OFS_PER_LO = 'h00;
    localparam int unsigned OFS_CNT_LO = 'h08;
    localparam int unsigned OFS_STATUS = 'h18;
    localparam int unsigned WORD_STEP  = 4;

    // control word bit positions
    localparam int unsigned CB_EN      = 0;
    localparam int unsigned CB_MODE    = 1;
    localparam int unsigned CB_UNMASK  = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HALT  = 2'd2
    } run_state_e;

    typedef struct packed {
        logic unmask;
        logic oneshot;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CTRL_OFS = 'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic                fire,
    input  logic                halt,
    output logic [CNT_W-1:0]    period,
    output ctrl_t               ctrl,
    output logic                status,
    output logic                arm,
    output logic                disarm,
    output logic                irq
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic        wr_ctrl;
    logic        wr_status;
    logic        clr_req;
    ctrl_t       ctrl_q;
    logic        status_q;
    logic [WORD_W-1:0] per_w [NWORDS];

    assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
    assign wr_status = bus_we && (bus_addr == A_STATUS);
    assign clr_req   = wr_status && bus_wdata[0];

    // period words, one register per bus word
    for (genvar w = 0; w < NWORDS; w++) begin : g_per
        localparam logic [ADDR_W-1:0] A_W = ADDR_W'(OFS_PER_LO + WORD_STEP * w);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                per_w[w] <= '0;
            end else if (bus_we && (bus_addr == A_W)) begin
                per_w[w] <= bus_wdata;
            end
        end
        assign period[w*WORD_W +: WORD_W] = per_w[w];
    end

    // control word; a one-shot expiry drops the enable bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en      <= bus_wdata[CB_EN] & ~halt;
            ctrl_q.oneshot <= bus_wdata[CB_MODE];
            ctrl_q.unmask  <= bus_wdata[CB_UNMASK];
        end else if (halt) begin
            ctrl_q.en      <= 1'b0;
        end
    end

    // sticky status: expiry wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (fire) begin
            status_q <= 1'b1;
        end else if (clr_req) begin
            status_q <= 1'b0;
        end
    end

    always_comb begin
        arm    = wr_ctrl &&  bus_wdata[CB_EN] && !ctrl_q.en;
        disarm = wr_ctrl && !bus_wdata[CB_EN] &&  ctrl_q.en;
        ctrl   = ctrl_q;
        status = status_q;
        irq    = status_q && ctrl_q.unmask;
    end

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              arm,
    input  logic              disarm,
    input  logic              oneshot,
    input  logic [CNT_W-1:0]  period,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  act_period,
    output logic              fire,
    output logic              halt,
    output logic              running
);

    run_state_e        state_q;
    run_state_e        state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  act_q;
    logic              at_end;
    logic              expire;

    assign at_end = (cnt_q == act_q);
    assign expire = (state_q == ST_COUNT) && tick_en && at_end && !disarm;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = ST_COUNT;                 // arm
            end
            ST_COUNT: begin
                if (disarm)               state_d = ST_IDLE;  // disarm
                else if (expire && oneshot) state_d = ST_HALT; // expire-once
            end
            ST_HALT: begin
                if (arm) state_d = ST_COUNT;                 // arm
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter and active period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (arm) begin
            cnt_q <= '0;
            act_q <= period;
        end else if ((state_q == ST_COUNT) && tick_en && !disarm) begin
            if (at_end) begin
                if (!oneshot) begin                          // expire-wrap
                    cnt_q <= '0;
                    act_q <= period;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cnt        = cnt_q;
        act_period = act_q;
        fire       = expire;
        halt       = expire && oneshot;
        running    = (state_q == ST_COUNT);
    end

endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CTRL_OFS = 'h10
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   period,
    input  logic [CNT_W-1:0]   cnt,
    input  ctrl_t              ctrl,
    input  logic               status,
    output logic [WORD_W-1:0]  bus_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic [WORD_W-1:0] per_hit [NWORDS];
    logic [WORD_W-1:0] cnt_hit [NWORDS];

    for (genvar w = 0; w < NWORDS; w++) begin : g_words
        localparam logic [ADDR_W-1:0] A_P = ADDR_W'(OFS_PER_LO + WORD_STEP * w);
        localparam logic [ADDR_W-1:0] A_C = ADDR_W'(OFS_CNT_LO + WORD_STEP * w);
        assign per_hit[w] = (bus_addr == A_P) ? period[w*WORD_W +: WORD_W] : '0;
        assign cnt_hit[w] = (bus_addr == A_C) ? cnt[w*WORD_W +: WORD_W]    : '0;
    end

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            bus_rdata = bus_rdata | per_hit[w] | cnt_hit[w];
        end
        if (bus_addr == A_CTRL) begin
            bus_rdata[CB_EN]     = ctrl.en;
            bus_rdata[CB_MODE]   = ctrl.oneshot;
            bus_rdata[CB_UNMASK] = ctrl.unmask;
        end
        if (bus_addr == A_STATUS) begin
            bus_rdata[0] = status;
        end
    end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CTRL_OFS = 'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq
);

    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] act_w;
    ctrl_t            ctrl_w;
    logic             status_w;
    logic             arm_w;
    logic             disarm_w;
    logic             fire_w;
    logic             halt_w;
    logic             running_w;

    ivt_regs #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .fire      (fire_w),
        .halt      (halt_w),
        .period    (period_w),
        .ctrl      (ctrl_w),
        .status    (status_w),
        .arm       (arm_w),
        .disarm    (disarm_w),
        .irq       (irq)
    );

    ivt_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .arm        (arm_w),
        .disarm     (disarm_w),
        .oneshot    (ctrl_w.oneshot),
        .period     (period_w),
        .cnt        (cnt_w),
        .act_period (act_w),
        .fire       (fire_w),
        .halt       (halt_w),
        .running    (running_w)
    );

    ivt_rdmux #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_rdmux (
        .bus_addr  (bus_addr),
        .period    (period_w),
        .cnt       (cnt_w),
        .ctrl      (ctrl_w),
        .status    (status_w),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CTRL_OFS = 'h10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic               irq,
    input logic [63:0]        cnt,
    input logic [63:0]        act_period,
    input logic               fire,
    input logic               running,
    input logic               ctrl_en,
    input logic               ctrl_oneshot,
    input logic               status
);

    logic wr_ctrl;
    logic start_wr;
    logic clr_wr;

    assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
    assign start_wr = wr_ctrl && bus_wdata[0] && !ctrl_en;
    assign clr_wr   = bus_we && (bus_addr == ADDR_W'('h18)) && bus_wdata[0];

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (cnt == 64'd0 && running)); // R3
    AST_RUN_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        running == ctrl_en); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !fire && !wr_ctrl) |=> (cnt == $past(cnt) + 64'd1)); // R4
    AST_HOLD_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !start_wr) |=> $stable(cnt)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ctrl_oneshot && !wr_ctrl) |=> (cnt == 64'd0)); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt <= act_period)); // R5
    AST_ONCE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ctrl_oneshot) |=> (!ctrl_en && !running && $stable(cnt))); // R6
    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> status); // R7
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_wr) |=> status); // R7
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !fire) |=> !irq); // R8

endmodule

bind ivt_timer ivt_checker #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .irq          (irq),
    .cnt          (cnt_w),
    .act_period   (act_w),
    .fire         (fire_w),
    .running      (running_w),
    .ctrl_en      (ctrl_w.en),
    .ctrl_oneshot (ctrl_w.oneshot),
    .status       (status_w)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;

    localparam logic [7:0] A_PLO  = 8'h00;
    localparam logic [7:0] A_PHI  = 8'h04;
    localparam logic [7:0] A_CLO  = 8'h08;
    localparam logic [7:0] A_CHI  = 8'h0C;
    localparam logic [7:0] A_CTRL = 8'h10;
    localparam logic [7:0] A_STAT = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ivt_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic longint unsigned exp_cnt(longint unsigned t, longint unsigned p, bit once);
        if (once) return (t > p) ? p : t;
        return t % (p + 1);
    endfunction

    function automatic bit exp_stat(longint unsigned t, longint unsigned p);
        return t > p;
    endfunction

    task automatic chk(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_cnt(output longint unsigned v);
        logic [31:0] lo;
        logic [31:0] hi;
        rd(A_CLO, lo);
        rd(A_CHI, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        longint unsigned c;
        int unsigned seed;
        seed = $urandom(32'd4242);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_PLO, d);  chk("R1 period lo", d, 0);
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd_cnt(c);     chk("R1 counter", c, 0);
        chk("R1 irq", irq, 0);

        // R2 period readback
        wr(A_PLO, 32'hDEAD_BEEF);
        wr(A_PHI, 32'h0000_0012);
        rd(A_PLO, d); chk("R2 period lo", d, 32'hDEAD_BEEF);
        rd(A_PHI, d); chk("R2 period hi", d, 32'h12);

        // R12 unmapped address
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, d);  chk("R12 unmapped read", d, 0);
        rd(A_PLO, d);  chk("R12 period untouched", d, 32'hDEAD_BEEF);
        rd(A_CTRL, d); chk("R12 ctrl untouched", d, 0);

        // R11 64-bit compare: period hi=1 lo=3
        wr(A_PLO, 3); wr(A_PHI, 1);
        wr(A_CTRL, 32'h1);
        ticks(10);
        rd_cnt(c);     chk("R11 counter past low match", c, 10);
        rd(A_STAT, d); chk("R11 no expiry", d, 0);
        wr(A_CTRL, 0);

        // R3 / R5 periodic, period 4, unmasked
        wr(A_PHI, 0); wr(A_PLO, 4);
        wr(A_CTRL, 32'h5);
        rd(A_CTRL, d); chk("R3 ctrl readback", d, 5);
        rd_cnt(c);     chk("R3 arm clears counter", c, 0);
        ticks(4);
        rd_cnt(c);     chk("R4 counter after 4 ticks", c, 4);
        rd(A_STAT, d); chk("R5 no early expiry", d, 0);
        repeat (3) @(negedge clk);
        rd_cnt(c);     chk("R4 holds without tick", c, 4);
        ticks(1);
        rd_cnt(c);     chk("R5 wrap to zero", c, 0);
        rd(A_STAT, d); chk("R5 status on expiry", d, 1);
        chk("R8 irq unmasked", irq, 1);
        wr(A_CTRL, 32'h5);
        ticks(2);
        rd_cnt(c);     chk("R3 rewrite no restart", c, 2);

        // R7 clear semantics
        wr(A_STAT, 0);
        rd(A_STAT, d); chk("R7 write 0 ignored", d, 1);
        wr(A_STAT, 1);
        rd(A_STAT, d); chk("R7 clear", d, 0);
        chk("R8 irq drops", irq, 0);

        // R9 period change mid-run: current period 4, counter 2
        wr(A_PLO, 6);
        ticks(3);
        rd_cnt(c);     chk("R9 old period still used", c, 0);
        rd(A_STAT, d); chk("R9 expiry at old period", d, 1);
        wr(A_STAT, 1);
        ticks(6);
        rd_cnt(c);     chk("R9 new period counter", c, 6);
        rd(A_STAT, d); chk("R9 no expiry before new end", d, 0);
        ticks(1);
        rd(A_STAT, d); chk("R9 expiry at new period", d, 1);

        // R10 disarm mid-run, tick in same cycle
        ticks(3);
        @(negedge clk);
        bus_addr = A_CTRL; bus_we = 1'b1; bus_wdata = 32'h4; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        rd_cnt(c);     chk("R10 stop wins over tick", c, 3);
        ticks(5);
        rd_cnt(c);     chk("R10 counter held", c, 3);
        rd(A_STAT, d); chk("R10 status kept", d, 1);
        chk("R8 irq with unmask while stopped", irq, 1);
        wr(A_STAT, 1);

        // R6 one-shot, masked, period 3
        wr(A_PLO, 3);
        wr(A_CTRL, 32'h3);
        ticks(4);
        rd_cnt(c);     chk("R6 counter frozen at period", c, 3);
        rd(A_STAT, d); chk("R6 status set", d, 1);
        rd(A_CTRL, d); chk("R6 enable cleared", d, 2);
        chk("R8 masked irq low", irq, 0);
        ticks(4);
        rd_cnt(c);     chk("R6 no further counting", c, 3);
        wr(A_CTRL, 32'h6);
        chk("R8 unmask raises irq", irq, 1);

        // R7 expiry and clear in same cycle, period 0
        wr(A_CTRL, 0); wr(A_STAT, 1);
        wr(A_PLO, 0);
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        bus_addr = A_STAT; bus_we = 1'b1; bus_wdata = 1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        rd(A_STAT, d); chk("R7 set beats clear", d, 1);
        wr(A_CTRL, 0);

        // random runs against the model
        for (int it = 0; it < 40; it++) begin
            int unsigned p;
            bit once;
            longint unsigned t;
            p = $urandom_range(0, 12);
            once = $urandom_range(0, 1);
            t = 0;
            wr(A_CTRL, 0);
            wr(A_STAT, 1);
            wr(A_PLO, p);
            wr(A_CTRL, {29'd0, 1'b1, once, 1'b1});
            for (int k = 0; k < 25; k++) begin
                @(negedge clk);
                tick_en = ($urandom_range(0, 1) == 1);
                if (tick_en) t++;
            end
            @(negedge clk);
            tick_en = 1'b0;
            rd_cnt(c);     chk(once ? "R6 random counter" : "R5 random counter", c, exp_cnt(t, p, once));
            rd(A_STAT, d); chk("R7 random status", d, exp_stat(t, p));
            chk("R8 random irq", irq, exp_stat(t, p));
            if (once) begin
                rd(A_CTRL, d); chk("R6 random enable", d[0], !exp_stat(t, p));
            end
        end

        finish_run();
    end

endmodule